// File: doc/BRIEF.md
# Cascadable Four-Bit ALU Slice

This block is a purely combinational arithmetic and logic unit built from four-bit slices. Each slice takes two four-bit operands, a three-bit operation select and a carry input. It produces a four-bit result, a carry output that feeds the next slice up, and a two's-complement overflow flag. Three select codes add or subtract, three select codes do bitwise logic, and the last two force the result to all zeros or all ones.

The top level chains a parameterised number of slices by ripple carry, so it can build 4-, 8-, 12- or 16-bit words. The carry input of the whole word enters the least significant slice. Each slice's carry out drives the carry in of the slice above it. Only the most significant slice's carry and overflow reach the ports.

The subtract codes do not inject a carry of their own. To get an exact difference, the user must drive the word carry input high. If the carry input is left low, the result is one less than the true difference.

Top module: `alu_ripple_word`

## Requirements
- R1: Select 3'b000 (clear) drives the result to all zeros, and carry out and overflow to 0, for any operands and carry in.
- R2: Select 3'b111 (preset) drives the result to all ones, and carry out and overflow to 0, for any operands and carry in.
- R3: Select 3'b011 computes {carry out, result} = A + B + carry in.
- R4: Select 3'b001 computes {carry out, result} = B + ~A + carry in. With carry in at 1 the result is B - A modulo 2^W.
- R5: Select 3'b010 computes {carry out, result} = A + ~B + carry in. With carry in at 1 the result is A - B modulo 2^W.
- R6: Select 3'b100 gives A XOR B, 3'b101 gives A OR B and 3'b110 gives A AND B. In these modes carry in has no effect and carry out and overflow are 0.
- R7: In the three arithmetic modes, overflow is the XOR of the carry into and the carry out of the top bit. It is 1 exactly when the signed two's-complement result does not fit in the word.
- R8: With SLICES slices chained, every mode of R1 to R7 holds for the full SLICES*4-bit word, with the carry rippling from slice to slice. The carry out and overflow ports come from the top slice only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | SLICES*4 | Operand A |
| b_i | input | SLICES*4 | Operand B |
| sel_i | input | 3 | Operation select, bit 2 most significant |
| cin_i | input | 1 | Carry into the least significant slice |
| f_o | output | SLICES*4 | Function result |
| cout_o | output | 1 | Carry out of the top slice |
| ovr_o | output | 1 | Signed overflow of the top slice |

## Verification
The bench drives a single-slice instance through every select code, every operand pair and both carry values. A design with the subtract operands swapped, or with a carry leaking into the logic modes, would therefore miss on some vector. Signed edge values such as 0x7FFF+1, 0x8000+0x8000 and 0x8000-1 catch an overflow taken from the wrong carry pair. A carry that ripples from the low byte into the high byte catches a broken link between slices. Subtractions with carry in low must give results exactly one below the true difference; a design that quietly inserts its own carry would give the true difference instead. Random signed operands on the 16-bit word are compared against integer arithmetic, with overflow judged from the integer range.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SLICE_BITS = 4;

    typedef enum logic [2:0] {
        OP_CLEAR   = 3'b000,
        OP_B_SUB_A = 3'b001,
        OP_A_SUB_B = 3'b010,
        OP_ADD     = 3'b011,
        OP_XOR     = 3'b100,
        OP_OR      = 3'b101,
        OP_AND     = 3'b110,
        OP_PRESET  = 3'b111
    } alu_op_e;

    function automatic logic op_is_arith(input alu_op_e op);
        return (op == OP_B_SUB_A) || (op == OP_A_SUB_B) || (op == OP_ADD);
    endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int BITS = SLICE_BITS
) (
    input  logic [BITS-1:0] a_i,
    input  logic [BITS-1:0] b_i,
    input  alu_op_e         op_i,
    input  logic            cin_i,
    output logic [BITS-1:0] f_o,
    output logic            cout_o,
    output logic            ovr_o
);

    localparam int TOP = BITS - 1;

    typedef struct packed {
        logic [BITS-1:0] f;
        logic            co;
        logic            ovr;
    } slice_res_t;

    slice_res_t      res_d;
    logic [BITS-1:0] opx_d;
    logic [BITS-1:0] opy_d;
    logic [BITS:0]   carry_d;

    // operand steering for the shared ripple adder
    always_comb begin
        unique case (op_i)
            OP_B_SUB_A: begin opx_d = ~a_i; opy_d = b_i;  end
            OP_A_SUB_B: begin opx_d = a_i;  opy_d = ~b_i; end
            default:    begin opx_d = a_i;  opy_d = b_i;  end
        endcase
    end

    // bit-serial ripple carry chain
    always_comb begin
        carry_d[0] = cin_i;
        for (int i = 0; i < BITS; i++) begin
            carry_d[i+1] = (opx_d[i] & opy_d[i]) | (carry_d[i] & (opx_d[i] ^ opy_d[i]));
        end
    end

    always_comb begin
        res_d = '0;
        unique case (op_i)
            OP_CLEAR:  res_d.f = '0;
            OP_PRESET: res_d.f = '1;
            OP_XOR:    res_d.f = a_i ^ b_i;
            OP_OR:     res_d.f = a_i | b_i;
            OP_AND:    res_d.f = a_i & b_i;
            default: begin
                res_d.f   = opx_d ^ opy_d ^ carry_d[BITS-1:0];
                res_d.co  = carry_d[BITS];
                res_d.ovr = carry_d[BITS] ^ carry_d[TOP];
            end
        endcase
    end

    assign f_o    = res_d.f;
    assign cout_o = res_d.co;
    assign ovr_o  = res_d.ovr;

    always_comb begin
        if (op_i == OP_CLEAR) begin
            assert_clear_zero_R1: assert (f_o == '0 && !cout_o && !ovr_o)
                else $error("clear code produced nonzero outputs");
        end
        if (op_i == OP_PRESET) begin
            assert_preset_ones_R2: assert (&f_o && !cout_o && !ovr_o)
                else $error("preset code produced wrong outputs");
        end
        if (!op_is_arith(op_i)) begin
            assert_logic_flags_low_R6: assert (!cout_o && !ovr_o)
                else $error("carry or overflow active outside arithmetic");
        end
        if (op_i == OP_ADD) begin
            assert_add_overflow_sign_R7: assert (ovr_o ==
                ((a_i[TOP] == b_i[TOP]) && (f_o[TOP] != a_i[TOP])))
                else $error("overflow disagrees with operand and result signs");
        end
    end

endmodule

// File: rtl/alu_ripple_word.sv
module alu_ripple_word
    import alu_slice_pkg::*;
#(
    parameter int SLICES = 4
) (
    input  logic [SLICES*4-1:0] a_i,
    input  logic [SLICES*4-1:0] b_i,
    input  logic [2:0]          sel_i,
    input  logic                cin_i,
    output logic [SLICES*4-1:0] f_o,
    output logic                cout_o,
    output logic                ovr_o
);

    localparam int W = SLICES * SLICE_BITS;

    alu_op_e           op_d;
    logic [SLICES:0]   link_d;
    logic [SLICES-1:0] slice_ovr_d;

    assign op_d      = alu_op_e'(sel_i);
    assign link_d[0] = cin_i;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        alu_slice #(.BITS(SLICE_BITS)) u_slice (
            .a_i    (a_i[k*SLICE_BITS +: SLICE_BITS]),
            .b_i    (b_i[k*SLICE_BITS +: SLICE_BITS]),
            .op_i   (op_d),
            .cin_i  (link_d[k]),
            .f_o    (f_o[k*SLICE_BITS +: SLICE_BITS]),
            .cout_o (link_d[k+1]),
            .ovr_o  (slice_ovr_d[k])
        );
    end

    assign cout_o = link_d[SLICES];
    assign ovr_o  = slice_ovr_d[SLICES-1];

    always_comb begin
        if (op_d == OP_ADD) begin
            assert_word_add_R8: assert ({cout_o, f_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i}))
                else $error("chained sum wrong");
        end
        if (op_d == OP_A_SUB_B) begin
            assert_word_sub_R5: assert ({cout_o, f_o} ==
                ({1'b0, a_i} + {1'b0, ~b_i} + {{W{1'b0}}, cin_i}))
                else $error("chained A minus B wrong");
        end
    end

endmodule

// File: tb/alu_ripple_word_tb.sv
module alu_ripple_word_tb;

    localparam int W = 16;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;

    logic [W-1:0] a, b, f;
    logic [2:0]   sel;
    logic         cin, co, ov;

    logic [3:0] sa, sb, sf;
    logic [2:0] ssel;
    logic       scin, sco, sov;

    alu_ripple_word #(.SLICES(4)) u_dut (
        .a_i(a), .b_i(b), .sel_i(sel), .cin_i(cin),
        .f_o(f), .cout_o(co), .ovr_o(ov));

    alu_ripple_word #(.SLICES(1)) u_slice1 (
        .a_i(sa), .b_i(sb), .sel_i(ssel), .cin_i(scin),
        .f_o(sf), .cout_o(sco), .ovr_o(sov));

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] a;
        logic [15:0] b;
        logic        cin;
        logic [15:0] f;
        logic        co;
        logic        ov;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'b011, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1},
        '{3'b011, 16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, 1'b0},
        '{3'b011, 16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1, 1'b1},
        '{3'b010, 16'h0000, 16'h0001, 1'b1, 16'hFFFF, 1'b0, 1'b0},
        '{3'b010, 16'h8000, 16'h0001, 1'b1, 16'h7FFF, 1'b1, 1'b1},
        '{3'b001, 16'h0003, 16'h0005, 1'b1, 16'h0002, 1'b1, 1'b0},
        '{3'b001, 16'h0003, 16'h0005, 1'b0, 16'h0001, 1'b1, 1'b0},
        '{3'b100, 16'hF0F0, 16'hFF00, 1'b1, 16'h0FF0, 1'b0, 1'b0},
        '{3'b101, 16'hF0F0, 16'h0F00, 1'b1, 16'hFFF0, 1'b0, 1'b0},
        '{3'b110, 16'hF0F0, 16'h3C3C, 1'b1, 16'h3030, 1'b0, 1'b0},
        '{3'b000, 16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 1'b0, 1'b0},
        '{3'b111, 16'h0000, 16'h0000, 1'b0, 16'hFFFF, 1'b0, 1'b0},
        '{3'b011, 16'h00FF, 16'h0001, 1'b1, 16'h0101, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] s);
        case (s)
            3'b000:  return "R1";
            3'b111:  return "R2";
            3'b011:  return "R3";
            3'b001:  return "R4";
            3'b010:  return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        a = '0; b = '0; sel = 3'b000; cin = 1'b1;
        sa = '0; sb = '0; ssel = 3'b000; scin = 1'b0;
        @(negedge clk);
        // quiescent state with clear code selected: R1
        check("R1", "initial clear result", {16'h0, f}, 32'h0);
        check("R1", "initial clear flags", {30'h0, co, ov}, 32'h0);

        // exhaustive single-slice sweep
        for (int s = 0; s < 8; s++) begin
            for (int x = 0; x < 16; x++) begin
                for (int y = 0; y < 16; y++) begin
                    for (int c = 0; c < 2; c++) begin
                        int ex, ey, sum, sx, sy, ssum;
                        logic [3:0] ef;
                        logic eco, eov;
                        @(posedge clk);
                        ssel = 3'(s); sa = 4'(x); sb = 4'(y); scin = 1'(c);
                        eco = 1'b0; eov = 1'b0;
                        case (s)
                            0: ef = 4'h0;
                            7: ef = 4'hF;
                            4: ef = 4'(x ^ y);
                            5: ef = 4'(x | y);
                            6: ef = 4'(x & y);
                            default: begin
                                ex = (s == 1) ? 15 - x : x;
                                ey = (s == 2) ? 15 - y : y;
                                sum = ex + ey + c;
                                ef = 4'(sum % 16);
                                eco = (sum >= 16);
                                sx = (ex >= 8) ? ex - 16 : ex;
                                sy = (ey >= 8) ? ey - 16 : ey;
                                ssum = sx + sy + c;
                                eov = (ssum > 7) || (ssum < -8); // R7
                            end
                        endcase
                        @(negedge clk);
                        check(req_of(3'(s)), "slice result", {28'h0, sf}, {28'h0, ef});
                        check((s >= 1 && s <= 3) ? "R7" : req_of(3'(s)),
                              "slice carry/overflow", {30'h0, sco, sov}, {30'h0, eco, eov});
                    end
                end
            end
        end

        // directed 16-bit vector table
        for (int i = 0; i < NV; i++) begin
            @(posedge clk);
            sel = VECS[i].sel; a = VECS[i].a; b = VECS[i].b; cin = VECS[i].cin;
            @(negedge clk);
            check("R8", "table result", {16'h0, f}, {16'h0, VECS[i].f});
            check("R8", "table carry", {31'h0, co}, {31'h0, VECS[i].co});
            check("R7", "table overflow", {31'h0, ov}, {31'h0, VECS[i].ov});
        end

        // carry in ignored in a logic mode on the wide word: R6
        @(posedge clk);
        sel = 3'b110; a = 16'hA5A5; b = 16'hFFFF; cin = 1'b0;
        @(negedge clk);
        check("R6", "AND with cin low", {16'h0, f}, 32'hA5A5);
        @(posedge clk);
        cin = 1'b1;
        @(negedge clk);
        check("R6", "AND with cin high", {16'h0, f}, 32'hA5A5);
        check("R6", "AND flags", {30'h0, co, ov}, 32'h0);

        // random signed operands against integer arithmetic
        for (int i = 0; i < 300; i++) begin
            int ia, ib, r;
            logic [2:0] op;
            @(posedge clk);
            a = 16'($urandom); b = 16'($urandom);
            op = 3'(1 + (i % 3));
            sel = op; cin = (op == 3'b011) ? 1'(i[2]) : 1'b1;
            ia = int'($signed(a)); ib = int'($signed(b));
            case (op)
                3'b001:  r = ib - ia;
                3'b010:  r = ia - ib;
                default: r = ia + ib + int'(cin);
            endcase
            @(negedge clk);
            check("R8", "random result", {16'h0, f}, {16'h0, 16'(r)});
            check("R7", "random overflow", {31'h0, ov},
                  {31'h0, (r > 32767) || (r < -32768)});
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule